// File: doc/BRIEF.md
# Module Power and Clock Sequencer

This block sits behind a 32-bit register port and moves a set of peripheral modules between four clock and reset states. Each module belongs to a power domain. Software writes the target state into a module's control word and then sets the domain's bit in the start register. The domain's sequencer then walks every module in the domain to its target. It shows busy until all of them are there, and the status words report the new state.

A domain that is unpowered cannot run a module transition. Software first sets the domain's power-on request bit and then issues the start. The sequencer raises a request line toward the external power switch, shows it as a pending bit, and holds until software writes the power-good bit. The domain then stays powered. Each module change gates or ungates its clock first. After a settling delay set by a parameter it applies the new reset level. A force bit skips that delay. A separate local-reset bit holds a module in reset at once, whatever its state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every module reports state 0 with its clock off and its reset output high. Domain status reads 1 for domains marked always-on and 0 for the others. The busy, pending and request outputs are all 0.
- R2: Registers are 32-bit words addressed in bytes:
  - pending flags at 0x070, start at 0x120 and busy at 0x128;
  - domain n status at 0x200+4n (bit 0 = powered) and domain n control at 0x300+4n (bit 0 = power-on request, bit 8 = power good);
  - module m status at 0xA00-region partner 0x800+4m, holding the state in bits [5:0] and clock running in bit 12;
  - module m control at 0xA00+4m, holding the target state in bits [1:0], local reset (active low) in bit 8 and force in bit 31.
- R3: State codes are 0 = reset with clock off, 1 = synchronous reset with clock on, 2 = out of reset with clock off, 3 = running. The clock-enable output equals status bit 12. The reset output is high in states 0 and 1.
- R4: Writing 1 to bit n of the start register while domain n is powered and idle sets busy bit n. When at least one module of the domain changes state without force, busy stays set for STEP_CYC+2 cycles. Each such module's status then equals its target.
- R5: During an unforced change the clock enable takes its new value first. The status field and the reset output follow STEP_CYC cycles later.
- R6: A module changing state with force set applies its clock and reset changes together. If every changing module is forced, busy lasts 2 cycles.
- R7: A start to a domain whose modules already sit at their targets keeps busy for 2 cycles and changes no output.
- R8: A start to a domain that is already busy is ignored. The running transition keeps the targets it latched at its start.
- R9: A start to an unpowered domain whose power-on request bit is set raises the pending bit and the request output, with busy set, until power good is written. The pending bit then clears, the domain reads powered, and the module changes proceed.
- R10: A start to an unpowered domain whose power-on request bit is clear is ignored, so busy, pending and module state stay unchanged.
- R11: Writing 0 to a module's local-reset bit drives its reset output high in the next cycle, without a start and without changing its state or clock. Writing 1 returns the output to the level its state gives.
- R12: Module m belongs to domain m mod N_DOM. A start for one domain leaves modules of other domains untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst | output | N_MOD | Per-module reset, active high |
| pwr_req | output | N_DOM | Per-domain power-switch request |

## Verification
The hardest situations to reach are those inside a transition. One is a second start landing while the first is still settling. Another is the window in which a domain waits for power good. The stimulus reaches the first by rewriting the target and issuing another start two cycles into a settling transition. It reaches the second by starting an unpowered domain and holding back power good for several cycles. The state is read through the register port in both windows. The mid-transition ordering of clock before reset is observed one cycle after the start takes effect. Random rounds then mix forced and unforced targets with local-reset bits across both domains.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_PEND  = 12'h070;
    localparam logic [ADDR_W-1:0] A_GO    = 12'h120;
    localparam logic [ADDR_W-1:0] A_BUSY  = 12'h128;
    localparam logic [ADDR_W-1:0] A_DSTAT = 12'h200;
    localparam logic [ADDR_W-1:0] A_DCTL  = 12'h300;
    localparam logic [ADDR_W-1:0] A_MSTAT = 12'h800;
    localparam logic [ADDR_W-1:0] A_MCTL  = 12'hA00;

    localparam int unsigned B_NEXT_ON = 0;
    localparam int unsigned B_PGOOD   = 8;
    localparam int unsigned B_LRST_N  = 8;
    localparam int unsigned B_CLK_RUN = 12;
    localparam int unsigned B_FORCE   = 31;

    typedef enum logic [1:0] {
        MS_OFF     = 2'd0,
        MS_SYNCRST = 2'd1,
        MS_GATED   = 2'd2,
        MS_ON      = 2'd3
    } mod_state_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_PWRUP,
        DS_KICK,
        DS_DRAIN
    } dom_state_e;

    typedef enum logic {
        MP_IDLE,
        MP_SETTLE
    } mod_phase_e;

    typedef struct packed {
        logic       force_go;
        logic       lrst_n;
        mod_state_e req;
    } mod_ctl_t;

    typedef struct packed {
        logic pwr_good;
        logic next_on;
    } dom_ctl_t;

    function automatic logic clk_runs(mod_state_e s);
        return (s == MS_SYNCRST) || (s == MS_ON);
    endfunction

    function automatic logic held_in_reset(mod_state_e s);
        return (s == MS_OFF) || (s == MS_SYNCRST);
    endfunction

    function automatic logic [ADDR_W-1:0] slot(logic [ADDR_W-1:0] base, int idx);
        return base + ADDR_W'(idx * 4);
    endfunction

endpackage

// File: rtl/pwr_seq_mod.sv
module pwr_seq_mod
    import pwr_seq_pkg::*;
#(
    parameter int unsigned STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       kick,
    input  mod_ctl_t   ctl,
    output logic [1:0] cur_o,
    output logic       clk_on,
    output logic       rst_out,
    output logic       idle
);
    localparam int unsigned CNT_W = (STEP > 1) ? $clog2(STEP) : 1;

    mod_phase_e       phase;
    mod_state_e       cur;
    mod_state_e       tgt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= MP_IDLE;
            cur    <= MS_OFF;
            tgt    <= MS_OFF;
            clk_on <= 1'b0;
            cnt    <= '0;
        end else begin
            case (phase)
                MP_IDLE: begin
                    if (kick && (ctl.req != cur)) begin
                        clk_on <= clk_runs(ctl.req);
                        tgt    <= ctl.req;
                        cnt    <= '0;
                        if (ctl.force_go) begin
                            cur <= ctl.req;
                        end else begin
                            phase <= MP_SETTLE;
                        end
                    end
                end
                MP_SETTLE: begin
                    if (cnt == CNT_W'(STEP - 1)) begin
                        cur   <= tgt;
                        phase <= MP_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= MP_IDLE;
            endcase
        end
    end

    assign cur_o   = cur;
    assign rst_out = held_in_reset(cur) || !ctl.lrst_n;
    assign idle    = (phase == MP_IDLE);

endmodule

// File: rtl/pwr_seq_dom.sv
module pwr_seq_dom
    import pwr_seq_pkg::*;
#(
    parameter bit ON_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic next_on,
    input  logic pwr_good,
    input  logic mods_idle,
    output logic busy,
    output logic pend,
    output logic powered,
    output logic kick
);
    dom_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= DS_IDLE;
            powered <= ON_AT_RESET;
        end else begin
            case (st)
                DS_IDLE: begin
                    if (go) begin
                        if (powered) begin
                            st <= DS_KICK;
                        end else if (next_on) begin
                            st <= DS_PWRUP;
                        end
                    end
                end
                DS_PWRUP: begin
                    if (pwr_good) begin
                        powered <= 1'b1;
                        st      <= DS_KICK;
                    end
                end
                DS_KICK:  st <= DS_DRAIN;
                DS_DRAIN: if (mods_idle) st <= DS_IDLE;
                default:  st <= DS_IDLE;
            endcase
        end
    end

    assign busy = (st != DS_IDLE);
    assign pend = (st == DS_PWRUP);
    assign kick = (st == DS_KICK);

endmodule

// File: rtl/pwr_seq_regs.sv
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int unsigned N_DOM = 2,
    parameter int unsigned N_MOD = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [31:0]                 bus_wdata,
    output logic [31:0]                 bus_rdata,
    input  logic [N_DOM-1:0]            dom_pend,
    input  logic [N_DOM-1:0]            dom_busy,
    input  logic [N_DOM-1:0]            dom_on,
    input  logic [N_MOD-1:0][1:0]       mod_cur,
    input  logic [N_MOD-1:0]            mod_clk,
    output mod_ctl_t [N_MOD-1:0]        mctl,
    output dom_ctl_t [N_DOM-1:0]        dctl,
    output logic [N_DOM-1:0]            go
);
    logic wr_en;
    logic unused_wdata;

    assign wr_en        = bus_sel && bus_wr;
    assign unused_wdata = ^bus_wdata;
    assign go           = (wr_en && (bus_addr == A_GO)) ? bus_wdata[N_DOM-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < N_MOD; m++) begin
                mctl[m].force_go <= 1'b0;
                mctl[m].lrst_n   <= 1'b1;
                mctl[m].req      <= MS_OFF;
            end
            for (int d = 0; d < N_DOM; d++) begin
                dctl[d] <= '0;
            end
        end else if (wr_en) begin
            for (int m = 0; m < N_MOD; m++) begin
                if (bus_addr == slot(A_MCTL, m)) begin
                    mctl[m].force_go <= bus_wdata[B_FORCE];
                    mctl[m].lrst_n   <= bus_wdata[B_LRST_N];
                    mctl[m].req      <= mod_state_e'(bus_wdata[1:0]);
                end
            end
            for (int d = 0; d < N_DOM; d++) begin
                if (bus_addr == slot(A_DCTL, d)) begin
                    dctl[d].next_on  <= bus_wdata[B_NEXT_ON];
                    dctl[d].pwr_good <= bus_wdata[B_PGOOD];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_PEND) bus_rdata[N_DOM-1:0] = dom_pend;
        if (bus_addr == A_BUSY) bus_rdata[N_DOM-1:0] = dom_busy;
        for (int d = 0; d < N_DOM; d++) begin
            if (bus_addr == slot(A_DSTAT, d)) begin
                bus_rdata[0] = dom_on[d];
            end
            if (bus_addr == slot(A_DCTL, d)) begin
                bus_rdata[B_NEXT_ON] = dctl[d].next_on;
                bus_rdata[B_PGOOD]   = dctl[d].pwr_good;
            end
        end
        for (int m = 0; m < N_MOD; m++) begin
            if (bus_addr == slot(A_MSTAT, m)) begin
                bus_rdata[1:0]       = mod_cur[m];
                bus_rdata[B_CLK_RUN] = mod_clk[m];
            end
            if (bus_addr == slot(A_MCTL, m)) begin
                bus_rdata[1:0]      = mctl[m].req;
                bus_rdata[B_LRST_N] = mctl[m].lrst_n;
                bus_rdata[B_FORCE]  = mctl[m].force_go;
            end
        end
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned      N_DOM     = 2,
    parameter int unsigned      N_MOD     = 4,
    parameter int unsigned      STEP_CYC  = 4,
    parameter logic [N_DOM-1:0] ALWAYS_ON = N_DOM'(1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_MOD-1:0]  mod_clk_en,
    output logic [N_MOD-1:0]  mod_rst,
    output logic [N_DOM-1:0]  pwr_req
);
    mod_ctl_t [N_MOD-1:0]  mctl;
    dom_ctl_t [N_DOM-1:0]  dctl;
    logic [N_DOM-1:0]      go;
    logic [N_DOM-1:0]      dom_busy;
    logic [N_DOM-1:0]      dom_on;
    logic [N_DOM-1:0]      dom_kick;
    logic [N_DOM-1:0]      dom_idle;
    logic [N_MOD-1:0]      mod_idle;
    logic [N_MOD-1:0][1:0] mod_cur;

    pwr_seq_regs #(
        .N_DOM (N_DOM),
        .N_MOD (N_MOD)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .dom_pend  (pwr_req),
        .dom_busy  (dom_busy),
        .dom_on    (dom_on),
        .mod_cur   (mod_cur),
        .mod_clk   (mod_clk_en),
        .mctl      (mctl),
        .dctl      (dctl),
        .go        (go)
    );

    always_comb begin
        dom_idle = '1;
        for (int m = 0; m < N_MOD; m++) begin
            if (!mod_idle[m]) dom_idle[m % N_DOM] = 1'b0;
        end
    end

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        pwr_seq_dom #(
            .ON_AT_RESET (ALWAYS_ON[d])
        ) u_dom (
            .clk       (clk),
            .rst       (rst),
            .go        (go[d]),
            .next_on   (dctl[d].next_on),
            .pwr_good  (dctl[d].pwr_good),
            .mods_idle (dom_idle[d]),
            .busy      (dom_busy[d]),
            .pend      (pwr_req[d]),
            .powered   (dom_on[d]),
            .kick      (dom_kick[d])
        );
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        localparam int D = m % N_DOM;
        pwr_seq_mod #(
            .STEP (STEP_CYC)
        ) u_mod (
            .clk     (clk),
            .rst     (rst),
            .kick    (dom_kick[D]),
            .ctl     (mctl[m]),
            .cur_o   (mod_cur[m]),
            .clk_on  (mod_clk_en[m]),
            .rst_out (mod_rst[m]),
            .idle    (mod_idle[m])
        );
    end

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk #(
    parameter int unsigned N_DOM = 2,
    parameter int unsigned N_MOD = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_DOM-1:0] pwr_req,
    input logic [N_DOM-1:0] dom_busy,
    input logic [N_DOM-1:0] dom_on,
    input logic [N_MOD-1:0] mod_clk_en
);
    for (genvar d = 0; d < N_DOM; d++) begin : g_d
        assert_pend_off_R9: assert property (@(posedge clk) disable iff (rst)
            $rose(pwr_req[d]) |-> !dom_on[d]);
        assert_on_sticky_R9: assert property (@(posedge clk) disable iff (rst)
            !$fell(dom_on[d]));
        assert_req_clears_R9: assert property (@(posedge clk) disable iff (rst)
            $fell(dom_busy[d]) |-> !pwr_req[d]);
        assert_busy_off_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
            dom_busy[d] |-> (dom_on[d] || pwr_req[d]));
    end

    for (genvar m = 0; m < N_MOD; m++) begin : g_m
        localparam int D = m % N_DOM;
        assert_clk_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
            !$stable(mod_clk_en[m]) |-> $past(dom_busy[D]));
    end
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk #(
    .N_DOM (N_DOM),
    .N_MOD (N_MOD)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_req    (pwr_req),
    .dom_busy   (dom_busy),
    .dom_on     (dom_on),
    .mod_clk_en (mod_clk_en)
);

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
    localparam int ND = 2;
    localparam int NM = 4;
    localparam int STEP = 4;
    localparam logic [11:0] R_PEND = 12'h070, R_GO = 12'h120, R_BUSY = 12'h128;
    localparam logic [11:0] R_DST = 12'h200, R_DCT = 12'h300, R_MST = 12'h800, R_MCT = 12'hA00;

    logic clk = 1'b0, rst = 1'b1, sel = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NM-1:0] clk_en, mrst;
    logic [ND-1:0] preq;

    pwr_seq_ctrl #(.N_DOM(ND), .N_MOD(NM), .STEP_CYC(STEP), .ALWAYS_ON(2'b01)) uut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .mod_clk_en(clk_en),
        .mod_rst(mrst), .pwr_req(preq)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int ms[NM];
    bit ml[NM];

    function automatic logic [31:0] exp_mstat(int s);
        return ((s == 1 || s == 3) ? 32'h1000 : 32'h0) | 32'(s);
    endfunction

    function automatic logic exp_rst(int s, bit l);
        return (s <= 1) || !l;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(logic [11:0] a, output logic [31:0] d);
        addr = a; sel = 1'b1; wr = 1'b0;
        #1;
        d = rdata;
        sel = 1'b0;
    endtask

    task automatic busy_len(int d, output int n);
        logic [31:0] v;
        n = 0;
        rd_reg(R_BUSY, v);
        while (v[d] && n < 500) begin
            n++;
            @(negedge clk);
            rd_reg(R_BUSY, v);
        end
    endtask

    task automatic check_mod(int m, string tag);
        logic [31:0] v;
        rd_reg(R_MST + 12'(4 * m), v);
        check({tag, " status"}, v, exp_mstat(ms[m]));
        check({tag, " clk_en"}, 32'(clk_en[m]), 32'(((ms[m] == 1) || (ms[m] == 3)) ? 1 : 0));
        check({tag, " rst"}, 32'(mrst[m]), 32'(exp_rst(ms[m], ml[m])));
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd4242));
        for (int m = 0; m < NM; m++) begin ms[m] = 0; ml[m] = 1'b1; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int m = 0; m < NM; m++) check_mod(m, "R1");
        rd_reg(R_DST, v);      check("R1 dom0 on", v, 32'h1);
        rd_reg(R_DST + 4, v);  check("R1 dom1 off", v, 32'h0);
        rd_reg(R_BUSY, v);     check("R1 busy", v, 32'h0);
        rd_reg(R_PEND, v);     check("R1 pend", v, 32'h0);
        check("R1 pwr_req", 32'(preq), 32'h0);

        // R4 / R3 / R12 basic enable in domain 0
        wr_reg(R_MCT + 4, 32'h103);
        wr_reg(R_MCT + 0, 32'h103);
        rd_reg(R_MCT + 0, v);  check("R2 control readback", v, 32'h103);
        wr_reg(R_GO, 32'h1);
        busy_len(0, n);        check("R4 busy length", 32'(n), 32'(STEP + 2));
        ms[0] = 3;
        check_mod(0, "R3");
        check_mod(1, "R12");
        check_mod(2, "R12");

        // R5 clock moves before reset
        wr_reg(R_MCT + 8, 32'h103);
        wr_reg(R_GO, 32'h1);
        @(negedge clk);
        check("R5 clock first", 32'(clk_en[2]), 32'h1);
        check("R5 reset held", 32'(mrst[2]), 32'h1);
        rd_reg(R_MST + 8, v);  check("R5 state held", {26'b0, v[5:0]}, 32'h0);
        busy_len(0, n);
        ms[2] = 3;
        check_mod(2, "R5");

        // R7 start with nothing to do
        wr_reg(R_GO, 32'h1);
        busy_len(0, n);        check("R7 busy length", 32'(n), 32'h2);
        check_mod(0, "R7");
        check_mod(2, "R7");

        // R6 forced change
        wr_reg(R_MCT + 0, 32'h8000_0102);
        wr_reg(R_GO, 32'h1);
        busy_len(0, n);        check("R6 busy length", 32'(n), 32'h2);
        ms[0] = 2;
        check_mod(0, "R6");

        // R8 start while busy is ignored
        wr_reg(R_MCT + 0, 32'h103);
        wr_reg(R_GO, 32'h1);
        wr_reg(R_MCT + 0, 32'h101);
        wr_reg(R_GO, 32'h1);
        busy_len(0, n);
        ms[0] = 3;
        check_mod(0, "R8");
        repeat (10) @(negedge clk);
        check_mod(0, "R8 later");

        // R10 unpowered domain without power-on request
        wr_reg(R_GO, 32'h2);
        rd_reg(R_BUSY, v);     check("R10 busy", v & 32'h2, 32'h0);
        rd_reg(R_PEND, v);     check("R10 pend", v, 32'h0);
        rd_reg(R_DST + 4, v);  check("R10 dom1 off", v, 32'h0);
        check_mod(1, "R10");

        // R9 power-up handshake
        wr_reg(R_DCT + 4, 32'h1);
        wr_reg(R_GO, 32'h2);
        rd_reg(R_PEND, v);     check("R9 pend set", v, 32'h2);
        rd_reg(R_BUSY, v);     check("R9 busy set", v, 32'h2);
        check("R9 pwr_req", 32'(preq), 32'h2);
        repeat (5) @(negedge clk);
        rd_reg(R_PEND, v);     check("R9 pend held", v, 32'h2);
        rd_reg(R_DST + 4, v);  check("R9 still off", v, 32'h0);
        check_mod(1, "R9 waiting");
        wr_reg(R_DCT + 4, 32'h101);
        busy_len(1, n);
        rd_reg(R_PEND, v);     check("R9 pend clear", v, 32'h0);
        rd_reg(R_DST + 4, v);  check("R9 powered", v, 32'h1);
        check("R9 pwr_req clear", 32'(preq), 32'h0);
        ms[1] = 3;
        check_mod(1, "R9");

        // R11 local reset
        wr_reg(R_MCT + 0, 32'h003);
        ml[0] = 1'b0;
        check_mod(0, "R11 asserted");
        wr_reg(R_MCT + 0, 32'h103);
        ml[0] = 1'b1;
        check_mod(0, "R11 released");

        // random rounds: R4 R6 R11 R12
        for (int it = 0; it < 40; it++) begin
            int d;
            bit slow;
            d = $urandom_range(0, 1);
            slow = 1'b0;
            for (int m = d; m < NM; m += ND) begin
                int r;
                bit f;
                bit l;
                r = $urandom_range(0, 3);
                f = 1'($urandom_range(0, 1));
                l = ($urandom_range(0, 3) != 0);
                wr_reg(R_MCT + 12'(4 * m), (f ? 32'h8000_0000 : 32'h0) | (l ? 32'h100 : 32'h0) | 32'(r));
                if (r != ms[m]) begin
                    if (!f) slow = 1'b1;
                    ms[m] = r;
                end
                ml[m] = l;
            end
            wr_reg(R_GO, 32'(1 << d));
            busy_len(d, n);
            check("R4 random busy length", 32'(n), slow ? 32'(STEP + 2) : 32'h2);
            for (int m = 0; m < NM; m++) check_mod(m, "R12 random");
        end

        summary();
        $finish;
    end
endmodule